// File: doc/BRIEF.md
# Delay-Line Phase Search and Tracking Controller

This block steers a 9-bit delay-line setting. It moves the setting until a phase code from an external detector equals a programmed target on a programmed slope, and then keeps it there. Each phase sample comes with a one-cycle valid strobe. The controller changes the delay by at most one decision per strobe. The next sample that arrives is therefore always a measurement of the new setting.

In full mode the block steps the delay from a loaded starting value until the phase equals the target. At that candidate it probes upward and then downward to learn which way the phase curve runs. It accepts the candidate only when the two probe results sit on opposite sides of the target in the order that the requested slope implies. After acceptance it tracks, one step per sample. A lock window of five codes drives a locked flag and a sticky lost flag. A loss can optionally restart the whole search. A search-only mode freezes the delay after acceptance. A track-only mode skips the search entirely. A read request copies the delay and phase captured at the moment of lock into readback registers.

Top module: `dlyPhaseTracker`

## Requirements
- R1: The delay output stays within 0 to 431 at all times. Steps saturate at both ends instead of wrapping. A starting value above 431 loads as 431.
- R2: When enable rises, the delay loads the starting value on the next clock. Mode 1 goes straight to tracking. Modes 0, 2 and 3 begin the search moving upward.
- R3: In search, each strobe whose phase differs from the target moves the delay by 1 in the current direction. The direction reverses at 431 and at 0. While enabled, the delay changes only on a strobe.
- R4: A strobe whose phase equals the target records that delay as the candidate and starts the upward probe at candidate+1. The downward probe then starts at candidate-1. Each probe ends on the first strobe that shows any of these:
  - the phase differs from the candidate's phase by 2 or more;
  - the phase is 16;
  - the phase is 0;
  - the delay is 431;
  - the delay is 0.
- R5: For a rising slope (wantNegSlope=0), the candidate is accepted when the upward-probe phase is above the target and the downward-probe phase is below it. For a falling slope the two conditions are swapped. On acceptance the delay returns to the candidate. On rejection the search resumes one step past the candidate.
- R6: After acceptance, modes 0 and 3 enter tracking with locked=1. Mode 2 sets locked=1 and then holds the delay regardless of later strobes.
- R7: In tracking with a rising slope, each strobe lowers the delay by 1 when the phase is above the target and raises it by 1 when the phase is below. A falling slope reverses both. An equal phase leaves the delay unchanged.
- R8: A tracking strobe whose phase is more than 5 codes from the target clears locked. It sets lost only if locked was 1 before that strobe. Lost stays set until enable drops.
- R9: On a loss in mode 0 or 3 with restartOnLoss=1, the delay reloads the starting value and the search restarts. With restartOnLoss=0, or in mode 1, tracking continues.
- R10: In tracking, a strobe within 5 codes of the target sets locked if it is clear. It also captures that strobe's delay and phase as the lock point.
- R11: A readReq pulse copies the lock-point delay and phase into rbDelay and rbPhase. Without readReq they hold their values. Both are 0 after reset.
- R12: Reset gives delay 0 and both flags 0. While enable is low the controller idles with both flags clear and the delay held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the controller; low returns to idle |
| mode | input | 2 | 0/3 full, 1 track only, 2 search only |
| targetPhase | input | 5 | Desired phase code |
| wantNegSlope | input | 1 | 1 selects a falling phase-versus-delay slope |
| restartOnLoss | input | 1 | Restart search when lock is lost (modes 0/3) |
| initDelay | input | 9 | Starting delay setting |
| phase | input | 5 | Measured phase code, 0 to 16 |
| phaseValid | input | 1 | One-cycle strobe qualifying phase |
| readReq | input | 1 | Capture lock point into readback |
| delayOut | output | 9 | Delay-line setting |
| locked | output | 1 | Phase within window of target |
| lost | output | 1 | Lock was held and then lost |
| rbDelay | output | 9 | Readback of delay at lock |
| rbPhase | output | 5 | Readback of phase at lock |

## Verification
Some properties hold on every cycle, and assertions check them:
- the delay stays in range;
- the delay never moves without a strobe;
- both flags clear once enable is low;
- lost rises only from a locked state;
- readback holds without a read request.

Other behaviour needs scenarios that only the bench can build:
- which candidate the slope probes accept or reject;
- the exact lock delays on a modelled phase curve;
- the direction reversal at the top of the range;
- the freeze in search-only mode;
- the restart-versus-stay choice on loss.

The bench's phase-detector model supplies these, and the tracking step rule is checked against it under random drift.

// File: rtl/dlyCtrlPkg.sv
`timescale 1ns/1ps
package dlyCtrlPkg;

  localparam logic [1:0] MODE_TRACK_ONLY  = 2'd1;
  localparam logic [1:0] MODE_SEARCH_ONLY = 2'd2;

  typedef enum logic [2:0] {
    OP_HOLD, OP_INIT, OP_INC, OP_DEC, OP_CAND, OP_CAND_INC, OP_CAND_DEC
  } delayOpE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEARCH, ST_PROBE_UP, ST_PROBE_DN, ST_TRACK, ST_HOLD
  } ctrlStateE;

  // strobes from control to datapath
  typedef struct packed {
    delayOpE op;
    logic    capCand;
    logic    capUp;
    logic    capLockCand;
    logic    capLockLive;
  } dpCmdT;

endpackage

// File: rtl/dlyCtrlDatapath.sv
`timescale 1ns/1ps
module dlyCtrlDatapath
  import dlyCtrlPkg::*;
#(
  parameter int DELAY_W    = 9,
  parameter int DELAY_MAX  = 431,
  parameter int PHASE_W    = 5,
  parameter int PHASE_MAX  = 16,
  parameter int LOCK_WIN   = 5,
  parameter int PROBE_SPAN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmdT              cmd,
  input  logic [PHASE_W-1:0] phase,
  input  logic [PHASE_W-1:0] targetPhase,
  input  logic               wantNegSlope,
  input  logic [DELAY_W-1:0] initDelay,
  input  logic               readReq,
  output logic [DELAY_W-1:0] delayOut,
  output logic [DELAY_W-1:0] rbDelay,
  output logic [PHASE_W-1:0] rbPhase,
  output logic               phaseAbove,
  output logic               phaseBelow,
  output logic               outOfWin,
  output logic               probeEnd,
  output logic               slopeOk,
  output logic               atMax,
  output logic               atMin
);

  localparam logic [DELAY_W-1:0] DLY_TOP = DELAY_W'(DELAY_MAX);
  localparam logic [PHASE_W-1:0] PH_TOP  = PHASE_W'(PHASE_MAX);
  localparam logic [PHASE_W-1:0] WIN     = PHASE_W'(LOCK_WIN);
  localparam logic [PHASE_W-1:0] SPAN    = PHASE_W'(PROBE_SPAN);

  logic [DELAY_W-1:0] delayQ, candQ, lockDelayQ, nextDelay, initClamped;
  logic [PHASE_W-1:0] basePhaseQ, upPhaseQ, lockPhaseQ;

  function automatic logic [DELAY_W-1:0] incSat(input logic [DELAY_W-1:0] v);
    return (v >= DLY_TOP) ? DLY_TOP : v + 1'b1;
  endfunction

  function automatic logic [DELAY_W-1:0] decSat(input logic [DELAY_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [PHASE_W-1:0] absDiff(input logic [PHASE_W-1:0] a,
                                                 input logic [PHASE_W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  assign initClamped = (initDelay > DLY_TOP) ? DLY_TOP : initDelay;

  always_comb begin
    case (cmd.op)
      OP_INIT:     nextDelay = initClamped;
      OP_INC:      nextDelay = incSat(delayQ);
      OP_DEC:      nextDelay = decSat(delayQ);
      OP_CAND:     nextDelay = candQ;
      OP_CAND_INC: nextDelay = incSat(candQ);
      OP_CAND_DEC: nextDelay = decSat(candQ);
      default:     nextDelay = delayQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayQ     <= '0;
      candQ      <= '0;
      basePhaseQ <= '0;
      upPhaseQ   <= '0;
      lockDelayQ <= '0;
      lockPhaseQ <= '0;
      rbDelay    <= '0;
      rbPhase    <= '0;
    end else begin
      delayQ <= nextDelay;
      if (cmd.capCand) begin
        candQ      <= delayQ;
        basePhaseQ <= phase;
      end
      if (cmd.capUp) upPhaseQ <= phase;
      if (cmd.capLockCand) begin
        lockDelayQ <= candQ;
        lockPhaseQ <= basePhaseQ;
      end else if (cmd.capLockLive) begin
        lockDelayQ <= delayQ;
        lockPhaseQ <= phase;
      end
      if (readReq) begin
        rbDelay <= lockDelayQ;
        rbPhase <= lockPhaseQ;
      end
    end
  end

  assign delayOut   = delayQ;
  assign atMax      = (delayQ >= DLY_TOP);
  assign atMin      = (delayQ == '0);
  assign phaseAbove = (phase > targetPhase);
  assign phaseBelow = (phase < targetPhase);
  assign outOfWin   = (absDiff(phase, targetPhase) > WIN);
  assign probeEnd   = (absDiff(phase, basePhaseQ) >= SPAN) || (phase >= PH_TOP) ||
                      (phase == '0) || atMax || atMin;
  // live phase is the downward-probe result when this is consulted
  assign slopeOk    = wantNegSlope ? (upPhaseQ < targetPhase && phase > targetPhase)
                                   : (upPhaseQ > targetPhase && phase < targetPhase);

endmodule

// File: rtl/dlyCtrlFsm.sv
`timescale 1ns/1ps
module dlyCtrlFsm
  import dlyCtrlPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       wantNegSlope,
  input  logic       restartOnLoss,
  input  logic       phaseValid,
  input  logic       phaseAbove,
  input  logic       phaseBelow,
  input  logic       outOfWin,
  input  logic       probeEnd,
  input  logic       slopeOk,
  input  logic       atMax,
  input  logic       atMin,
  output dpCmdT      cmd,
  output logic       locked,
  output logic       lost
);

  ctrlStateE state, stateN;
  logic searchUp, searchUpN, trackOnly, trackOnlyN, searchOnly, searchOnlyN;
  logic lockedN, lostN;
  delayOpE trackOp;

  always_comb begin
    if (phaseAbove)      trackOp = wantNegSlope ? OP_INC : OP_DEC;
    else if (phaseBelow) trackOp = wantNegSlope ? OP_DEC : OP_INC;
    else                 trackOp = OP_HOLD;
  end

  always_comb begin
    cmd         = '0;
    stateN      = state;
    searchUpN   = searchUp;
    trackOnlyN  = trackOnly;
    searchOnlyN = searchOnly;
    lockedN     = locked;
    lostN       = lost;
    if (!enable) begin
      stateN  = ST_IDLE;
      lockedN = 1'b0;
      lostN   = 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cmd.op      = OP_INIT;
          trackOnlyN  = (mode == MODE_TRACK_ONLY);
          searchOnlyN = (mode == MODE_SEARCH_ONLY);
          searchUpN   = 1'b1;
          stateN      = (mode == MODE_TRACK_ONLY) ? ST_TRACK : ST_SEARCH;
        end
        ST_SEARCH: if (phaseValid) begin
          if (!phaseAbove && !phaseBelow) begin
            cmd.capCand = 1'b1;
            cmd.op      = OP_INC;
            stateN      = ST_PROBE_UP;
          end else if (searchUp) begin
            if (atMax) begin searchUpN = 1'b0; cmd.op = OP_DEC; end
            else cmd.op = OP_INC;
          end else begin
            if (atMin) begin searchUpN = 1'b1; cmd.op = OP_INC; end
            else cmd.op = OP_DEC;
          end
        end
        ST_PROBE_UP: if (phaseValid) begin
          if (probeEnd) begin
            cmd.capUp = 1'b1;
            cmd.op    = OP_CAND_DEC;
            stateN    = ST_PROBE_DN;
          end else cmd.op = OP_INC;
        end
        ST_PROBE_DN: if (phaseValid) begin
          if (!probeEnd) cmd.op = OP_DEC;
          else if (slopeOk) begin
            cmd.op          = OP_CAND;
            cmd.capLockCand = 1'b1;
            lockedN         = 1'b1;
            stateN          = searchOnly ? ST_HOLD : ST_TRACK;
          end else begin
            cmd.op = searchUp ? OP_CAND_INC : OP_CAND_DEC;
            stateN = ST_SEARCH;
          end
        end
        ST_TRACK: if (phaseValid) begin
          if (outOfWin) begin
            lockedN = 1'b0;
            if (locked) lostN = 1'b1;
            if (locked && restartOnLoss && !trackOnly) begin
              cmd.op    = OP_INIT;
              searchUpN = 1'b1;
              stateN    = ST_SEARCH;
            end else cmd.op = trackOp;
          end else begin
            cmd.op = trackOp;
            if (!locked) begin
              lockedN         = 1'b1;
              cmd.capLockLive = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      searchUp   <= 1'b1;
      trackOnly  <= 1'b0;
      searchOnly <= 1'b0;
      locked     <= 1'b0;
      lost       <= 1'b0;
    end else begin
      state      <= stateN;
      searchUp   <= searchUpN;
      trackOnly  <= trackOnlyN;
      searchOnly <= searchOnlyN;
      locked     <= lockedN;
      lost       <= lostN;
    end
  end

endmodule

// File: rtl/dlyPhaseTracker.sv
`timescale 1ns/1ps
module dlyPhaseTracker
  import dlyCtrlPkg::*;
#(
  parameter int DELAY_W    = 9,
  parameter int DELAY_MAX  = 431,
  parameter int PHASE_W    = 5,
  parameter int PHASE_MAX  = 16,
  parameter int LOCK_WIN   = 5,
  parameter int PROBE_SPAN = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         mode,
  input  logic [PHASE_W-1:0] targetPhase,
  input  logic               wantNegSlope,
  input  logic               restartOnLoss,
  input  logic [DELAY_W-1:0] initDelay,
  input  logic [PHASE_W-1:0] phase,
  input  logic               phaseValid,
  input  logic               readReq,
  output logic [DELAY_W-1:0] delayOut,
  output logic               locked,
  output logic               lost,
  output logic [DELAY_W-1:0] rbDelay,
  output logic [PHASE_W-1:0] rbPhase
);

  dpCmdT cmd;
  logic phaseAbove, phaseBelow, outOfWin, probeEnd, slopeOk, atMax, atMin;

  dlyCtrlFsm u_fsm (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .wantNegSlope(wantNegSlope), .restartOnLoss(restartOnLoss),
    .phaseValid(phaseValid), .phaseAbove(phaseAbove), .phaseBelow(phaseBelow),
    .outOfWin(outOfWin), .probeEnd(probeEnd), .slopeOk(slopeOk),
    .atMax(atMax), .atMin(atMin), .cmd(cmd), .locked(locked), .lost(lost)
  );

  dlyCtrlDatapath #(
    .DELAY_W(DELAY_W), .DELAY_MAX(DELAY_MAX), .PHASE_W(PHASE_W),
    .PHASE_MAX(PHASE_MAX), .LOCK_WIN(LOCK_WIN), .PROBE_SPAN(PROBE_SPAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .phase(phase), .targetPhase(targetPhase),
    .wantNegSlope(wantNegSlope), .initDelay(initDelay), .readReq(readReq),
    .delayOut(delayOut), .rbDelay(rbDelay), .rbPhase(rbPhase),
    .phaseAbove(phaseAbove), .phaseBelow(phaseBelow), .outOfWin(outOfWin),
    .probeEnd(probeEnd), .slopeOk(slopeOk), .atMax(atMax), .atMin(atMin)
  );

endmodule

// File: rtl/dlyPhaseTrackerChk.sv
`timescale 1ns/1ps
module dlyPhaseTrackerChk #(
  parameter int DELAY_W   = 9,
  parameter int DELAY_MAX = 431,
  parameter int PHASE_W   = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               phaseValid,
  input logic               readReq,
  input logic [DELAY_W-1:0] delayOut,
  input logic               locked,
  input logic               lost,
  input logic [DELAY_W-1:0] rbDelay,
  input logic [PHASE_W-1:0] rbPhase
);

  localparam logic [DELAY_W-1:0] DLY_TOP = DELAY_W'(DELAY_MAX);

  assert_delay_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    delayOut <= DLY_TOP);

  assert_still_without_strobe_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && $past(rstN) && !phaseValid) |=> $stable(delayOut));

  assert_lost_after_lock_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lost) |-> $past(locked));

  assert_readback_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !readReq |=> ($stable(rbDelay) && $stable(rbPhase)));

  assert_idle_flags_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!locked && !lost));

endmodule

bind dlyPhaseTracker dlyPhaseTrackerChk #(
  .DELAY_W(DELAY_W), .DELAY_MAX(DELAY_MAX), .PHASE_W(PHASE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .phaseValid(phaseValid),
  .readReq(readReq), .delayOut(delayOut), .locked(locked), .lost(lost),
  .rbDelay(rbDelay), .rbPhase(rbPhase)
);

// File: tb/tb_dlyPhaseTracker.sv
`timescale 1ns/1ps
module tb_dlyPhaseTracker;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [4:0] targetPhase = 5'd8;
  logic       wantNegSlope = 1'b0;
  logic       restartOnLoss = 1'b0;
  logic [8:0] initDelay = 9'd0;
  logic [4:0] phaseIn = 5'd0;
  logic       phaseValid = 1'b0;
  logic       readReq = 1'b0;
  logic [8:0] delayOut, rbDelay;
  logic [4:0] rbPhase;
  logic       locked, lost;

  int vectors = 0;
  int fails = 0;
  int curveOff = 0;
  bit constMode = 0;
  int constVal = 0;

  always #2 clk = ~clk;

  dlyPhaseTracker dut (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode), .targetPhase(targetPhase),
    .wantNegSlope(wantNegSlope), .restartOnLoss(restartOnLoss), .initDelay(initDelay),
    .phase(phaseIn), .phaseValid(phaseValid), .readReq(readReq),
    .delayOut(delayOut), .locked(locked), .lost(lost), .rbDelay(rbDelay), .rbPhase(rbPhase)
  );

  // phase detector model: triangle of period 68, two delay steps per code
  function automatic int curveAt(int d);
    int pos;
    if (constMode) return constVal;
    pos = (d + curveOff) % 68;
    return (pos < 34) ? pos / 2 : (67 - pos) / 2;
  endfunction

  function automatic int expStep(int d, int p, int t, bit neg);
    int r = d;
    if (p > t)      r = neg ? d + 1 : d - 1;
    else if (p < t) r = neg ? d - 1 : d + 1;
    if (r < 0) r = 0;
    if (r > 431) r = 431;
    return r;
  endfunction

  function automatic int distOf(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(output int usedPhase, output int usedDelay);
    @(negedge clk);
    usedDelay  = int'(delayOut);
    usedPhase  = curveAt(usedDelay);
    phaseIn    = 5'(usedPhase);
    phaseValid = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic startRun(input int m, input int t, input bit neg, input bit rst, input int init);
    @(negedge clk);
    enable = 1'b0;
    mode = 2'(m); targetPhase = 5'(t); wantNegSlope = neg;
    restartOnLoss = rst; initDelay = 9'(init);
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic runSearch(output int lockDly);
    int p, d;
    lockDly = -1;
    for (int n = 0; n < 2500 && !locked; n++) strobe(p, d);
    if (locked) lockDly = int'(delayOut);
  endtask

  task automatic pulseRead();
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
  endtask

  task automatic makeFar(input int t);
    for (int o = 0; o < 68; o++) begin
      curveOff = o;
      if (distOf(curveAt(int'(delayOut)), t) > 5) break;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int p, d, lk, held, expD;
    bit expL, expLost;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(delayOut == 0 && !locked && !lost, "R12 reset state", int'(delayOut), 0);
    check(rbDelay == 0 && rbPhase == 0, "R11 readback reset", int'(rbDelay), 0);

    // full mode, rising slope, target 8, start 100
    curveOff = 0; constMode = 0;
    startRun(0, 8, 0, 0, 100);
    check(delayOut == 100, "R2 start load", int'(delayOut), 100);
    strobe(p, d);
    check(delayOut == 101, "R3 search step up", int'(delayOut), 101);
    runSearch(lk);
    check(lk == 152, "R5 rising slope accepted after falling rejects", lk, 152);
    check(locked == 1, "R6 locked on acceptance", int'(locked), 1);
    check(curveAt(lk) == 8, "R4 candidate phase equals target", curveAt(lk), 8);
    check(rbDelay == 0, "R11 readback holds before read", int'(rbDelay), 0);
    pulseRead();
    check(rbDelay == 152 && rbPhase == 8, "R11 readback lock delay", int'(rbDelay), 152);

    // tracking under random small drift
    for (int i = 0; i < 40; i++) begin
      if ($urandom % 4 == 0) curveOff = (curveOff < 6) ? curveOff + 1 : curveOff;
      else if ($urandom % 4 == 0) curveOff = (curveOff > 0) ? curveOff - 1 : 0;
      strobe(p, d);
      expD = expStep(d, p, 8, 0);
      check(int'(delayOut) == expD, "R7 rising track step", int'(delayOut), expD);
      check(locked == 1 && lost == 0, "R10 stays locked in window", int'(locked), 1);
    end

    // loss without restart
    makeFar(8);
    strobe(p, d);
    check(locked == 0, "R8 locked clears beyond window", int'(locked), 0);
    check(lost == 1, "R8 lost after prior lock", int'(lost), 1);
    expD = expStep(d, p, 8, 0);
    check(int'(delayOut) == expD, "R9 stays tracking without restart", int'(delayOut), expD);

    // enable low
    @(negedge clk); enable = 1'b0; held = int'(delayOut);
    @(negedge clk); @(negedge clk);
    check(!locked && !lost, "R12 flags clear when disabled", int'(lost), 0);
    check(int'(delayOut) == held, "R12 delay held while idle", int'(delayOut), held);

    // loss with restart
    curveOff = 0;
    startRun(0, 8, 0, 1, 100);
    runSearch(lk);
    check(lk == 152, "R6 relock before restart test", lk, 152);
    makeFar(8);
    strobe(p, d);
    check(int'(delayOut) == 100, "R9 restart reloads start delay", int'(delayOut), 100);
    check(lost == 1 && locked == 0, "R8 lost on restart", int'(lost), 1);

    // falling slope, start at top, reversal
    curveOff = 0;
    startRun(3, 6, 1, 0, 431);
    strobe(p, d);
    check(delayOut == 430, "R3 reverse at top", int'(delayOut), 430);
    runSearch(lk);
    check(lk == 395, "R5 falling slope accepted", lk, 395);

    // search only freezes
    curveOff = 0;
    startRun(2, 8, 0, 0, 100);
    runSearch(lk);
    check(lk == 152 && locked, "R6 search-only lock", lk, 152);
    for (int i = 0; i < 6; i++) begin
      curveOff = 3 * i + 5;
      strobe(p, d);
    end
    check(delayOut == 152 && locked, "R6 search-only holds delay", int'(delayOut), 152);

    // track only with constant detector
    constMode = 1; constVal = 3;
    startRun(1, 10, 0, 1, 5);
    check(delayOut == 5, "R2 track-only start load", int'(delayOut), 5);
    strobe(p, d);
    check(delayOut == 6, "R7 track raises below target", int'(delayOut), 6);
    check(!locked && !lost, "R8 no lost without prior lock", int'(lost), 0);
    strobe(p, d);
    constVal = 7;
    strobe(p, d);
    check(locked == 1, "R10 track-only lock inside window", int'(locked), 1);
    check(int'(delayOut) == d + 1, "R7 step while locking", int'(delayOut), d + 1);
    pulseRead();
    check(int'(rbDelay) == d && rbPhase == 7, "R11 readback live lock point", int'(rbDelay), d);
    constVal = 2;
    strobe(p, d);
    check(!locked && lost, "R8 loss in track-only", int'(lost), 1);
    check(int'(delayOut) == d + 1, "R9 track-only ignores restart", int'(delayOut), d + 1);

    // clamps and falling-slope direction
    constVal = 3;
    startRun(1, 10, 0, 0, 431);
    strobe(p, d);
    check(delayOut == 431, "R1 saturate at top", int'(delayOut), 431);
    startRun(1, 10, 0, 0, 500);
    check(delayOut == 431, "R1 start value clamped", int'(delayOut), 431);
    constVal = 15;
    startRun(1, 10, 0, 0, 0);
    strobe(p, d);
    check(delayOut == 0, "R1 saturate at bottom", int'(delayOut), 0);
    constVal = 3;
    startRun(1, 10, 1, 0, 200);
    strobe(p, d);
    check(delayOut == 199, "R7 falling slope lowers below target", int'(delayOut), 199);

    // random track-only runs against the step and flag model
    constMode = 0;
    for (int r = 0; r < 8; r++) begin
      int t, init;
      bit neg;
      t = 3 + int'($urandom % 11);
      neg = 1'($urandom % 2);
      init = int'($urandom % 432);
      curveOff = int'($urandom % 68);
      startRun(1, t, neg, 1'($urandom % 2), init);
      expL = 0; expLost = 0;
      for (int i = 0; i < 60; i++) begin
        if ($urandom % 4 == 0) curveOff = (curveOff + 1) % 68;
        strobe(p, d);
        expD = expStep(d, p, t, neg);
        if (distOf(p, t) > 5) begin
          if (expL) expLost = 1;
          expL = 0;
        end else expL = 1;
        check(int'(delayOut) == expD, "R7 random track step", int'(delayOut), expD);
        check(locked == expL, "R10 random lock flag", int'(locked), int'(expL));
        check(lost == expLost, "R8 random lost flag", int'(lost), int'(expLost));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule